// File: doc/BRIEF.md
# Interrupt Event Trace Recorder

This block keeps a short, ordered history of the interrupt events that a bus controller raises while it carries out one transfer. Each event arrives as an interrupt bit vector with a one-cycle valid strobe. Two byte counts travel with it: the bytes pushed into the transmit FIFO and the bytes taken from the receive FIFO. The recorder stamps each event with the value of its own free-running tick counter. When an event repeats the interrupt pattern of the newest record, that record absorbs it and no new entry is used. The record keeps a repeat count and running byte totals for the merged events.

A start-of-transfer pulse empties the trace, so what remains afterwards describes only the most recent transfer. Software reads the history through an indexed port. That port returns one record together with the number of valid records, one clock later. When the memory is full, new entries are refused and a sticky flag records the loss.

Top module: `evtrace_rec`

## Requirements
- R1: After reset the record count is 0, the overflow flag is 0, and every field on the read port is 0.
- R2: A valid event whose interrupt pattern differs from the newest record, or that arrives when the trace is empty, is written at index equal to the current record count. The record holds repeat count 1 and the event's interrupt, TX and RX values, and the record count rises by one.
- R3: The tick counter is 0 at the first rising clock edge with reset released and rises by one at every edge after that. A record stores the counter value seen at the edge that captures its event.
- R4: A valid event with the same interrupt pattern as the newest record leaves the record count unchanged. It adds 1 to that record's repeat count, which saturates at 65535. It adds its TX and RX values to that record's totals, each saturating at 255, and it keeps the record's tick.
- R5: Records stay in arrival order. A pattern that recurs after a different pattern starts a new record, and cycles with no valid event change nothing.
- R6: The trace holds 16 records. When it is full, a non-merging event is dropped and the overflow flag rises and stays high until the next transfer start. Merging into the newest record still works while the trace is full.
- R7: A transfer-start pulse on its own sets the record count to 0 and clears the overflow flag. If a valid event arrives in the same cycle, the trace holds exactly that event at index 0.
- R8: The read port registers the record at the requested index, together with the record count, one cycle after the index is presented. An index at or above the record count returns all-zero fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start_i | input | 1 | Start of a new transfer; empties the trace |
| evt_valid_i | input | 1 | Single-cycle event strobe |
| evt_irq_i | input | 16 | Interrupt bit pattern of the event |
| evt_tx_i | input | 8 | Bytes added to the transmit FIFO for this event |
| evt_rx_i | input | 8 | Bytes read from the receive FIFO for this event |
| rd_idx_i | input | 4 | Record index to read |
| rd_cnt_o | output | 16 | Repeat count of the addressed record |
| rd_irq_o | output | 16 | Interrupt pattern of the addressed record |
| rd_tx_o | output | 8 | TX byte total of the addressed record |
| rd_rx_o | output | 8 | RX byte total of the addressed record |
| rd_tick_o | output | 32 | Tick stamp of the addressed record |
| rd_fill_o | output | 5 | Number of valid records |
| ovf_o | output | 1 | Sticky flag: an event was dropped because the trace was full |

## Verification
The bound checker watches properties that hold on every cycle. The record count never exceeds the depth and never rises by more than one. It stays the same in cycles with no event and is emptied by a transfer start. The overflow flag stays set until a transfer start, and it can only rise from a full trace. The read port reports the count one cycle late. What goes into each record can only be shown by the bench's scenarios: the field values, the tick stamps, saturation of the repeat count and byte totals, arrival order, and what a full trace refuses and still accepts. The bench runs these scenarios against a model built from the requirements.

// File: rtl/evtrace_pkg.sv
package evtrace_pkg;
   // Action the control unit picks for the current cycle
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_NEW   = 2'd1,
      ACT_MERGE = 2'd2,
      ACT_DROP  = 2'd3
   } evt_act_e;
endpackage

// File: rtl/evtrace_tick.sv
module evtrace_tick #(
   parameter int TICK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TICK_W-1:0] tick_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_o <= '0;
      else        tick_o <= tick_o + 1'b1;
   end
endmodule

// File: rtl/evtrace_ctrl.sv
module evtrace_ctrl
   import evtrace_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IRQ_W = 16,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              valid_i,
   input  logic [IRQ_W-1:0]  irq_i,
   input  logic [IRQ_W-1:0]  last_irq_i,
   output logic [IDX_W-1:0]  last_idx_o,
   output evt_act_e          act_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [FILL_W-1:0] fill_o,
   output logic              ovf_o
);
   localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

   logic [FILL_W-1:0] fill_d;
   logic [FILL_W-1:0] fill_m1;
   logic              ovf_d;

   assign fill_m1    = fill_o - FILL_W'(1);
   assign last_idx_o = fill_m1[IDX_W-1:0];

   always_comb begin
      act_o    = ACT_IDLE;
      wr_idx_o = '0;
      fill_d   = fill_o;
      ovf_d    = ovf_o;
      if (clear_i) begin
         fill_d = '0;
         ovf_d  = 1'b0;
         if (valid_i) begin
            act_o  = ACT_NEW;
            fill_d = FILL_W'(1);
         end
      end else if (valid_i) begin
         if ((fill_o != '0) && (irq_i == last_irq_i)) begin
            act_o    = ACT_MERGE;
            wr_idx_o = last_idx_o;
         end else if (fill_o == FULL) begin
            act_o = ACT_DROP;
            ovf_d = 1'b1;
         end else begin
            act_o    = ACT_NEW;
            wr_idx_o = fill_o[IDX_W-1:0];
            fill_d   = fill_o + FILL_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_o <= '0;
         ovf_o  <= 1'b0;
      end else begin
         fill_o <= fill_d;
         ovf_o  <= ovf_d;
      end
   end
endmodule

// File: rtl/evtrace_store.sv
module evtrace_store
   import evtrace_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int IRQ_W  = 16,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16,
   parameter int TICK_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  evt_act_e          act_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [IRQ_W-1:0]  irq_i,
   input  logic [BYTE_W-1:0] tx_i,
   input  logic [BYTE_W-1:0] rx_i,
   input  logic [TICK_W-1:0] tick_i,
   input  logic [IDX_W-1:0]  last_idx_i,
   output logic [IRQ_W-1:0]  last_irq_o,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [CNT_W-1:0]  rd_cnt_o,
   output logic [IRQ_W-1:0]  rd_irq_o,
   output logic [BYTE_W-1:0] rd_tx_o,
   output logic [BYTE_W-1:0] rd_rx_o,
   output logic [TICK_W-1:0] rd_tick_o
);
   logic [CNT_W-1:0]  cnt_a  [DEPTH];
   logic [IRQ_W-1:0]  irq_a  [DEPTH];
   logic [BYTE_W-1:0] tx_a   [DEPTH];
   logic [BYTE_W-1:0] rx_a   [DEPTH];
   logic [TICK_W-1:0] tick_a [DEPTH];

   function automatic logic [BYTE_W-1:0] sat_add(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
      logic [BYTE_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[BYTE_W] ? '1 : s[BYTE_W-1:0];
   endfunction

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic              hit;
      logic [CNT_W-1:0]  cnt_q;
      logic [IRQ_W-1:0]  irq_q;
      logic [BYTE_W-1:0] tx_q;
      logic [BYTE_W-1:0] rx_q;
      logic [TICK_W-1:0] tick_q;

      assign hit = (wr_idx_i == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            irq_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            tick_q <= '0;
         end else if (hit && (act_i == ACT_NEW)) begin
            cnt_q  <= CNT_W'(1);
            irq_q  <= irq_i;
            tx_q   <= tx_i;
            rx_q   <= rx_i;
            tick_q <= tick_i;
         end else if (hit && (act_i == ACT_MERGE)) begin
            if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
            tx_q <= sat_add(tx_q, tx_i);
            rx_q <= sat_add(rx_q, rx_i);
         end
      end

      assign cnt_a[e]  = cnt_q;
      assign irq_a[e]  = irq_q;
      assign tx_a[e]   = tx_q;
      assign rx_a[e]   = rx_q;
      assign tick_a[e] = tick_q;
   end

   assign last_irq_o = irq_a[last_idx_i];
   assign rd_cnt_o   = cnt_a[rd_idx_i];
   assign rd_irq_o   = irq_a[rd_idx_i];
   assign rd_tx_o    = tx_a[rd_idx_i];
   assign rd_rx_o    = rx_a[rd_idx_i];
   assign rd_tick_o  = tick_a[rd_idx_i];
endmodule

// File: rtl/evtrace_rdport.sv
module evtrace_rdport #(
   parameter int DEPTH  = 16,
   parameter int IRQ_W  = 16,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16,
   parameter int TICK_W = 32,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx_i,
   input  logic [FILL_W-1:0] fill_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [IRQ_W-1:0]  irq_i,
   input  logic [BYTE_W-1:0] tx_i,
   input  logic [BYTE_W-1:0] rx_i,
   input  logic [TICK_W-1:0] tick_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [IRQ_W-1:0]  irq_o,
   output logic [BYTE_W-1:0] tx_o,
   output logic [BYTE_W-1:0] rx_o,
   output logic [TICK_W-1:0] tick_o,
   output logic [FILL_W-1:0] fill_o
);
   logic in_range;
   assign in_range = (FILL_W'(rd_idx_i) < fill_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o  <= '0;
         irq_o  <= '0;
         tx_o   <= '0;
         rx_o   <= '0;
         tick_o <= '0;
         fill_o <= '0;
      end else begin
         fill_o <= fill_i;
         if (in_range) begin
            cnt_o  <= cnt_i;
            irq_o  <= irq_i;
            tx_o   <= tx_i;
            rx_o   <= rx_i;
            tick_o <= tick_i;
         end else begin
            cnt_o  <= '0;
            irq_o  <= '0;
            tx_o   <= '0;
            rx_o   <= '0;
            tick_o <= '0;
         end
      end
   end
endmodule

// File: rtl/evtrace_rec.sv
module evtrace_rec
   import evtrace_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int IRQ_W  = 16,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16,
   parameter int TICK_W = 32,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start_i,
   input  logic              evt_valid_i,
   input  logic [IRQ_W-1:0]  evt_irq_i,
   input  logic [BYTE_W-1:0] evt_tx_i,
   input  logic [BYTE_W-1:0] evt_rx_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [CNT_W-1:0]  rd_cnt_o,
   output logic [IRQ_W-1:0]  rd_irq_o,
   output logic [BYTE_W-1:0] rd_tx_o,
   output logic [BYTE_W-1:0] rd_rx_o,
   output logic [TICK_W-1:0] rd_tick_o,
   output logic [FILL_W-1:0] rd_fill_o,
   output logic              ovf_o
);
   // Elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("evtrace_rec: DEPTH must be a power of two and at least 2");
   end
   if (IRQ_W < 1 || BYTE_W < 1 || CNT_W < 2 || TICK_W < 1) begin : g_bad_width
      $error("evtrace_rec: field widths out of range");
   end

   evt_act_e          act;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  last_idx;
   logic [IRQ_W-1:0]  last_irq;
   logic [FILL_W-1:0] fill_q;
   logic [TICK_W-1:0] tick;
   logic [CNT_W-1:0]  s_cnt;
   logic [IRQ_W-1:0]  s_irq;
   logic [BYTE_W-1:0] s_tx;
   logic [BYTE_W-1:0] s_rx;
   logic [TICK_W-1:0] s_tick;

   evtrace_tick #(.TICK_W(TICK_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick)
   );

   evtrace_ctrl #(.DEPTH(DEPTH), .IRQ_W(IRQ_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .clear_i(xfer_start_i), .valid_i(evt_valid_i),
      .irq_i(evt_irq_i), .last_irq_i(last_irq),
      .last_idx_o(last_idx), .act_o(act), .wr_idx_o(wr_idx),
      .fill_o(fill_q), .ovf_o(ovf_o)
   );

   evtrace_store #(
      .DEPTH(DEPTH), .IRQ_W(IRQ_W), .BYTE_W(BYTE_W),
      .CNT_W(CNT_W), .TICK_W(TICK_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .act_i(act), .wr_idx_i(wr_idx),
      .irq_i(evt_irq_i), .tx_i(evt_tx_i), .rx_i(evt_rx_i), .tick_i(tick),
      .last_idx_i(last_idx), .last_irq_o(last_irq),
      .rd_idx_i(rd_idx_i),
      .rd_cnt_o(s_cnt), .rd_irq_o(s_irq), .rd_tx_o(s_tx),
      .rd_rx_o(s_rx), .rd_tick_o(s_tick)
   );

   evtrace_rdport #(
      .DEPTH(DEPTH), .IRQ_W(IRQ_W), .BYTE_W(BYTE_W),
      .CNT_W(CNT_W), .TICK_W(TICK_W)
   ) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_idx_i(rd_idx_i), .fill_i(fill_q),
      .cnt_i(s_cnt), .irq_i(s_irq), .tx_i(s_tx), .rx_i(s_rx), .tick_i(s_tick),
      .cnt_o(rd_cnt_o), .irq_o(rd_irq_o), .tx_o(rd_tx_o), .rx_o(rd_rx_o),
      .tick_o(rd_tick_o), .fill_o(rd_fill_o)
   );
endmodule

// File: rtl/evtrace_rec_chk.sv
module evtrace_rec_chk #(
   parameter int DEPTH  = 16,
   parameter int FILL_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear_i,
   input logic              valid_i,
   input logic [FILL_W-1:0] fill,
   input logic              ovf,
   input logic [FILL_W-1:0] rd_fill
);
   assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH));

   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i && !valid_i) |=> (fill == '0) && !ovf);

   assert_clear_with_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i && valid_i) |=> (fill == FILL_W'(1)));

   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clear_i) |=> ovf);

   assert_ovf_from_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf && !clear_i && valid_i && fill != FILL_W'(DEPTH)) |=> !ovf);

   assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (fill == $past(fill)) || (fill == $past(fill) + FILL_W'(1)));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !clear_i) |=> $stable(fill) && $stable(ovf));

   assert_rd_fill_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rd_fill == $past(fill)));
endmodule

bind evtrace_rec evtrace_rec_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear_i(xfer_start_i), .valid_i(evt_valid_i),
   .fill(fill_q), .ovf(ovf_o), .rd_fill(rd_fill_o)
);

// File: tb/sim_evtrace_rec.sv
module sim_evtrace_rec;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   typedef struct packed {
      logic        clr;
      logic        vld;
      logic [15:0] irq;
      logic [7:0]  tx;
      logic [7:0]  rx;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 1'b1, 16'h0002, 8'd3,   8'd0},   // new record (R2)
      '{1'b0, 1'b1, 16'h0200, 8'd0,   8'd0},   // new record
      '{1'b0, 1'b1, 16'h0200, 8'd1,   8'd2},   // merge (R4)
      '{1'b0, 1'b0, 16'h0000, 8'd0,   8'd0},   // idle gap (R5)
      '{1'b0, 1'b1, 16'h0200, 8'd0,   8'd0},   // merge after gap
      '{1'b0, 1'b1, 16'h0080, 8'd0,   8'd8},   // new record
      '{1'b0, 1'b1, 16'h0002, 8'd5,   8'd0},   // recurring pattern -> new (R5)
      '{1'b0, 1'b1, 16'h0002, 8'd200, 8'd0},   // merge
      '{1'b0, 1'b1, 16'h0002, 8'd100, 8'd1}    // merge, tx saturates
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0;
   logic        evt_valid = 1'b0;
   logic [15:0] evt_irq = '0;
   logic [7:0]  evt_tx = '0;
   logic [7:0]  evt_rx = '0;
   logic [3:0]  rd_idx = '0;
   logic [15:0] rd_cnt;
   logic [15:0] rd_irq;
   logic [7:0]  rd_tx;
   logic [7:0]  rd_rx;
   logic [31:0] rd_tick;
   logic [4:0]  rd_fill;
   logic        ovf;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // Bench copy of the tick (R3)
   logic [31:0] tc;

   // Model state
   logic [15:0] m_irq  [DEPTH];
   logic [15:0] m_cnt  [DEPTH];
   logic [7:0]  m_tx   [DEPTH];
   logic [7:0]  m_rx   [DEPTH];
   logic [31:0] m_tick [DEPTH];
   int          m_fill = 0;
   bit          m_ovf = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tc <= '0;
      else        tc <= tc + 1;
   end

   evtrace_rec u0 (
      .clk(clk), .rst_n(rst_n), .xfer_start_i(xfer_start),
      .evt_valid_i(evt_valid), .evt_irq_i(evt_irq), .evt_tx_i(evt_tx),
      .evt_rx_i(evt_rx), .rd_idx_i(rd_idx),
      .rd_cnt_o(rd_cnt), .rd_irq_o(rd_irq), .rd_tx_o(rd_tx), .rd_rx_o(rd_rx),
      .rd_tick_o(rd_tick), .rd_fill_o(rd_fill), .ovf_o(ovf)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] sadd(input logic [7:0] a, input logic [7:0] b);
      int s;
      s = int'(a) + int'(b);
      return (s > 255) ? 8'd255 : 8'(s);
   endfunction

   // Drive one cycle of stimulus and update the model
   task automatic ev(input logic clr, input logic vld, input logic [15:0] irq,
                     input logic [7:0] tx, input logic [7:0] rx);
      @(negedge clk);
      xfer_start = clr;
      evt_valid  = vld;
      evt_irq    = irq;
      evt_tx     = tx;
      evt_rx     = rx;
      if (clr) begin
         m_fill = 0;
         m_ovf  = 1'b0;
      end
      if (vld) begin
         if (!clr && m_fill != 0 && irq == m_irq[m_fill-1]) begin
            if (m_cnt[m_fill-1] != 16'hFFFF) m_cnt[m_fill-1] += 16'd1;
            m_tx[m_fill-1] = sadd(m_tx[m_fill-1], tx);
            m_rx[m_fill-1] = sadd(m_rx[m_fill-1], rx);
         end else if (m_fill == DEPTH) begin
            m_ovf = 1'b1;
         end else begin
            m_irq[m_fill]  = irq;
            m_cnt[m_fill]  = 16'd1;
            m_tx[m_fill]   = tx;
            m_rx[m_fill]   = rx;
            m_tick[m_fill] = tc;
            m_fill++;
         end
      end
   endtask

   task automatic idle();
      ev(1'b0, 1'b0, 16'h0, 8'h0, 8'h0);
   endtask

   task automatic check_all(input string req);
      idle();
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         rd_idx = 4'(i);
         @(negedge clk);
         chk(req, "fill", rd_fill, m_fill);
         if (i < m_fill) begin
            chk(req, $sformatf("cnt[%0d]", i),  rd_cnt,  m_cnt[i]);
            chk(req, $sformatf("irq[%0d]", i),  rd_irq,  m_irq[i]);
            chk(req, $sformatf("tx[%0d]", i),   rd_tx,   m_tx[i]);
            chk(req, $sformatf("rx[%0d]", i),   rd_rx,   m_rx[i]);
            chk("R3", $sformatf("tick[%0d]", i), rd_tick, m_tick[i]);
         end else begin
            chk("R8", $sformatf("empty slot %0d", i),
                {rd_cnt, rd_irq, rd_tx, rd_rx} | rd_tick, 0);
         end
      end
      chk(req, "overflow flag", ovf, m_ovf);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk("R1", "fill after reset", rd_fill, 0);
      chk("R1", "overflow after reset", ovf, 0);
      chk("R1", "read fields after reset", {rd_cnt, rd_irq, rd_tx, rd_rx} | rd_tick, 0);

      // Vector table: R2, R4, R5
      for (int v = 0; v < NVEC; v++)
         ev(VEC[v].clr, VEC[v].vld, VEC[v].irq, VEC[v].tx, VEC[v].rx);
      check_all("R5");

      // R7: transfer start together with an event
      ev(1'b1, 1'b1, 16'h0010, 8'd1, 8'd1);
      check_all("R7");

      // R6: fill to the limit, drop, then merge while full
      ev(1'b1, 1'b0, 16'h0, 8'h0, 8'h0);
      for (int k = 0; k < DEPTH; k++)
         ev(1'b0, 1'b1, 16'(k + 1), 8'(k), 8'(2 * k));
      ev(1'b0, 1'b1, 16'h8000, 8'd9, 8'd9);
      ev(1'b0, 1'b1, 16'(DEPTH), 8'd4, 8'd4);
      check_all("R6");

      // R6: flag stays up across idle cycles
      repeat (5) idle();
      chk("R6", "overflow sticky", ovf, 1);

      // R7: transfer start alone empties and clears the flag
      ev(1'b1, 1'b0, 16'h0, 8'h0, 8'h0);
      check_all("R7");

      // R4: repeat count and byte totals saturate
      ev(1'b0, 1'b1, 16'h4000, 8'd0, 8'd0);
      for (int k = 0; k < 65540; k++)
         ev(1'b0, 1'b1, 16'h4000, 8'd1, 8'd3);
      check_all("R4");
      chk("R4", "count saturated", m_cnt[0], 16'hFFFF);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule